// File: doc/BRIEF.md
# Quad DAC Register and Power Controller

This block is the digital control core of a four-channel digital-to-analogue converter. Every channel holds a 16-bit code and a 4-bit span, each kept in two stages: an input stage that commands write, and an active stage that stands for what the converter drives. A transfer copies the input stage into the active stage. Commands arrive from a serial front end, which is modelled here as a parallel strobe carrying a 4-bit opcode, a 4-bit address and a 16-bit data word. A chip-select level frames each transaction.

A clear input empties only the active stage, so a later transfer brings back the earlier state. A sticky active-low integrity flag reports that the outputs may not match what the host expects, and it returns high only on a valid update. Channels can be put to sleep one at a time. Each pair of channels (A/B, C/D) shares a reference-amplifier enable, and that enable drops only when both channels of the pair sleep. A span read latches a status word that holds the channel's active span and its sleep bit.

Transactions pass through a four-state sequencer. IDLE moves to OPEN when chip select falls with clear high, and to ABORT when chip select falls with clear low. OPEN moves to DONE when a command is accepted, to ABORT when clear is seen, and back to IDLE when chip select rises. DONE and ABORT both return to IDLE when chip select rises. The sequencer accepts a command only in OPEN. It registers that command and executes it in the next cycle. The clear, load and low-supply inputs are sampled on the clock.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After reset every code and span in both stages is zero, all channels are awake (power enables 1111, reference enables 11), the integrity flag is low and the readback word is zero.
- R2: Opcode 4'b0000 writes data into the input code, and opcode 4'b0001 writes data[3:0] into the input span, of the addressed channels. Neither changes any active value. Opcodes without a listed meaning have no effect.
- R3: Opcode 4'b0010 (update) copies the input stage into the active stage of the addressed channels. Address 0..3 selects channel A..D, address 4'hF selects all four channels, and any other address selects none.
- R4: While load_n is low, every channel's input stage is copied into its active stage on each clock, and every channel is woken.
- R5: While clr_n is low, the active codes and spans are held at zero and the input stages are kept, so a later update restores the earlier active values.
- R6: If clr_n is low while chip select is low, the rest of that transaction is discarded. A command strobed before chip select rises is not executed.
- R7: integ_n goes low on reset, on clear and while low_supply is high. It returns high only after an update opcode with a valid address executes.
- R8: Opcode 4'b1110 puts the addressed channels to sleep, and their power enables drop. Active values are unchanged.
- R9: The reference enable of pair A/B (bit 0) or C/D (bit 1) is low exactly when both channels of that pair are asleep.
- R10: An update that addresses a sleeping channel wakes it.
- R11: Opcode 4'b1010 with address 0..3 loads the readback word as {11'b0, sleep, active span}: the sleep bit is bit 4 (1 = asleep) and the span is in bits [3:0]. Other addresses leave the readback word unchanged.
- R12: Only the first strobe inside one chip-select frame is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| clr_n | input | 1 | System clear, active low, sampled on the clock |
| cs_n | input | 1 | Transaction frame, low while a transaction is open |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd | input | 4 | Opcode |
| addr | input | 4 | Channel address |
| data | input | 16 | Code or span payload |
| load_n | input | 1 | Load-all strobe, active low |
| low_supply | input | 1 | Low logic-supply indication |
| code_act_o | output | 64 | Active codes, channel A in bits [15:0] |
| span_act_o | output | 16 | Active spans, channel A in bits [3:0] |
| pwr_en_o | output | 4 | Per-channel power enable (1 = awake) |
| ref_en_o | output | 2 | Shared reference-amplifier enables |
| integ_n_o | output | 1 | Integrity flag, active low |
| rdbk_o | output | 16 | Readback status word |

## Verification
A wrong sequencer state shows up as a command that is lost or executed twice. The active outputs then differ from the expected values two clocks after the strobe. A corrupted input stage stays hidden until the next update, load or clear-then-update, which is why the bench follows each clear and each abort with an update and checks the restored values. A wrong sleep bit shows up in the power and reference enables at once, and in the readback word two clocks after a span read.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
    typedef enum logic [3:0] {
        OP_WR_CODE = 4'b0000,
        OP_WR_SPAN = 4'b0001,
        OP_UPDATE  = 4'b0010,
        OP_RD_SPAN = 4'b1010,
        OP_SLEEP   = 4'b1110
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OPEN,
        S_DONE,
        S_ABORT
    } st_e;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;
endpackage

// File: rtl/qdc_seq.sv
module qdc_seq
    import qdc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              exec_q,
    output logic [3:0]        cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    st_e  state, nxt;
    logic accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (!cs_n) nxt = clr_n ? S_OPEN : S_ABORT;
            S_OPEN: begin
                if (!clr_n)         nxt = S_ABORT;
                else if (cs_n)      nxt = S_IDLE;
                else if (cmd_valid) nxt = S_DONE;
            end
            S_DONE:  if (cs_n) nxt = S_IDLE;
            S_ABORT: if (cs_n) nxt = S_IDLE;
        endcase
    end

    assign accept = (state == S_OPEN) && !cs_n && cmd_valid && clr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_q <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (!clr_n) begin
            exec_q <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            exec_q <= accept;
            if (accept) begin
                cmd_q  <= cmd;
                addr_q <= addr;
                data_q <= data;
            end
        end
    end

    // R6: a clear inside an open frame prevents any later execution in it
    assert_abort_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !cs_n) |=> ##1 !exec_q);
    // R12: one execution per frame
    assert_single_exec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> !exec_q);
    assert_exec_in_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> state == S_DONE);
endmodule

// File: rtl/qdc_chan.sv
module qdc_chan
    import qdc_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int SPAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              exec,
    input  logic              sel,
    input  logic [3:0]        op,
    input  logic [CODE_W-1:0] code_wr,
    input  logic [SPAN_W-1:0] span_wr,
    input  logic              load_n,
    output logic [CODE_W-1:0] code_act,
    output logic [SPAN_W-1:0] span_act,
    output logic              asleep
);
    logic [CODE_W-1:0] code_in;
    logic [SPAN_W-1:0] span_in;
    logic              hit, do_xfer;

    assign hit     = exec && sel && clr_n;
    assign do_xfer = !load_n || (hit && op == OP_UPDATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_in <= '0;
            span_in <= '0;
        end else if (hit) begin
            if (op == OP_WR_CODE) code_in <= code_wr;
            if (op == OP_WR_SPAN) span_in <= span_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_act <= '0;
            span_act <= '0;
            asleep   <= 1'b0;
        end else if (!clr_n) begin
            code_act <= '0;
            span_act <= '0;
        end else if (do_xfer) begin
            code_act <= code_in;
            span_act <= span_in;
            asleep   <= 1'b0;
        end else if (hit && op == OP_SLEEP) begin
            asleep <= 1'b1;
        end
    end

    // R5: clear empties the active stage and keeps the input stage
    assert_clear_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (code_act == '0) && (span_act == '0));
    assert_clear_keeps_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> $stable(code_in) && $stable(span_in));
    // R10: an update wakes the channel with the input values
    assert_update_wakes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_UPDATE) |=> !asleep && code_act == $past(code_in));
    // R8: sleep leaves active values untouched
    assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_SLEEP && load_n) |=> asleep && $stable(code_act));
endmodule

// File: rtl/qdc_power.sv
module qdc_power #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]   asleep,
    output logic [NCH/2-1:0] ref_en
);
    for (genvar p = 0; p < NCH / 2; p++) begin : g_pair
        assign ref_en[p] = !(asleep[2*p] && asleep[2*p+1]);
    end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
    import qdc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 16,
    parameter int SPAN_W = 4,
    parameter int RB_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  cs_n,
    input  logic                  cmd_valid,
    input  logic [3:0]            cmd,
    input  logic [3:0]            addr,
    input  logic [CODE_W-1:0]     data,
    input  logic                  load_n,
    input  logic                  low_supply,
    output logic [NCH*CODE_W-1:0] code_act_o,
    output logic [NCH*SPAN_W-1:0] span_act_o,
    output logic [NCH-1:0]        pwr_en_o,
    output logic [NCH/2-1:0]      ref_en_o,
    output logic                  integ_n_o,
    output logic [RB_W-1:0]       rdbk_o
);
    localparam int SLP_BIT = SPAN_W;

    logic              exec_q;
    logic [3:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CODE_W-1:0] data_q;
    logic [NCH-1:0]    sel, asleep;
    logic              addr_ok, rd_hit, upd_ok;
    logic [SPAN_W-1:0] rd_span;
    logic              rd_slp;

    qdc_seq #(.DATA_W(CODE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n),
        .cmd_valid(cmd_valid), .cmd(cmd), .addr(addr), .data(data),
        .exec_q(exec_q), .cmd_q(cmd_q), .addr_q(addr_q), .data_q(data_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign sel[i] = (addr_q == ADDR_ALL) || (addr_q == ADDR_W'(i));
        qdc_chan #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .exec(exec_q),
            .sel(sel[i]), .op(cmd_q), .code_wr(data_q),
            .span_wr(data_q[SPAN_W-1:0]), .load_n(load_n),
            .code_act(code_act_o[i*CODE_W +: CODE_W]),
            .span_act(span_act_o[i*SPAN_W +: SPAN_W]),
            .asleep(asleep[i])
        );
    end

    qdc_power #(.NCH(NCH)) u_power (.asleep(asleep), .ref_en(ref_en_o));

    assign pwr_en_o = ~asleep;
    assign addr_ok  = |sel;
    assign upd_ok   = exec_q && clr_n && cmd_q == OP_UPDATE && addr_ok;
    assign rd_hit   = exec_q && clr_n && cmd_q == OP_RD_SPAN && addr_q != ADDR_ALL && addr_ok;

    always_comb begin
        rd_span = '0;
        rd_slp  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (addr_q == ADDR_W'(i)) begin
                rd_span = span_act_o[i*SPAN_W +: SPAN_W];
                rd_slp  = asleep[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     integ_n_o <= 1'b0;
        else if (!clr_n || low_supply)  integ_n_o <= 1'b0;
        else if (upd_ok)                integ_n_o <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdbk_o <= '0;
        else if (rd_hit) begin
            rdbk_o          <= '0;
            rdbk_o[SLP_BIT] <= rd_slp;
            rdbk_o[SPAN_W-1:0] <= rd_span;
        end
    end

    // R7: clear or low supply forces the flag low
    assert_flag_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n || low_supply) |=> !integ_n_o);
    // R7: the flag rises only following an executed update
    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integ_n_o) |-> $past(exec_q));
    // R9: a pair's reference stays on while either channel is awake
    for (genvar p = 0; p < NCH / 2; p++) begin : g_chk
        assert_ref_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_en_o[2*p] || pwr_en_o[2*p+1]) |-> ref_en_o[p]);
    end
endmodule

// File: tb/quad_dac_ctrl_tb.sv
module quad_dac_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, cmd_valid = 1'b0;
    logic [3:0]  cmd = '0, addr = '0;
    logic [15:0] data = '0;
    logic        load_n = 1'b1, low_supply = 1'b0;
    logic [63:0] code_act_o;
    logic [15:0] span_act_o;
    logic [3:0]  pwr_en_o;
    logic [1:0]  ref_en_o;
    logic        integ_n_o;
    logic [15:0] rdbk_o;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_ci[4], m_ca[4];
    logic [3:0]  m_si[4], m_sa[4];
    logic        m_sl[4];
    logic        m_flag;
    logic [15:0] m_rb;

    always #5 clk = ~clk;

    quad_dac_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd(cmd), .addr(addr), .data(data), .load_n(load_n), .low_supply(low_supply),
        .code_act_o(code_act_o), .span_act_o(span_act_o), .pwr_en_o(pwr_en_o),
        .ref_en_o(ref_en_o), .integ_n_o(integ_n_o), .rdbk_o(rdbk_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic picks(input logic [3:0] a, input int i);
        return (a == 4'hF) || (a == 4'(i));
    endfunction

    task automatic check_all(input string req);
        logic [63:0] ec;
        logic [15:0] es;
        logic [3:0]  ep;
        logic [1:0]  er;
        ec = '0; es = '0; ep = '0;
        for (int i = 0; i < 4; i++) begin
            ec[i*16 +: 16] = m_ca[i];
            es[i*4 +: 4]   = m_sa[i];
            ep[i]          = !m_sl[i];
        end
        er[0] = !(m_sl[0] && m_sl[1]);
        er[1] = !(m_sl[2] && m_sl[3]);
        chk({req, " code"}, code_act_o, ec);
        chk({req, " span"}, {48'd0, span_act_o}, {48'd0, es});
        chk({req, " pwr"}, {60'd0, pwr_en_o}, {60'd0, ep});
        chk({req, " ref"}, {62'd0, ref_en_o}, {62'd0, er});
        chk({req, " flag"}, {63'd0, integ_n_o}, {63'd0, m_flag});
        chk({req, " rdbk"}, {48'd0, rdbk_o}, {48'd0, m_rb});
    endtask

    task automatic model(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        for (int i = 0; i < 4; i++) begin
            if (picks(a, i)) begin
                case (c)
                    4'b0000: m_ci[i] = d;
                    4'b0001: m_si[i] = d[3:0];
                    4'b0010: begin m_ca[i] = m_ci[i]; m_sa[i] = m_si[i]; m_sl[i] = 1'b0; end
                    4'b1110: m_sl[i] = 1'b1;
                    default: ;
                endcase
            end
        end
        if (c == 4'b0010 && (a == 4'hF || a < 4)) m_flag = 1'b1;
        if (c == 4'b1010 && a < 4) m_rb = {11'd0, m_sl[a], m_sa[a]};
    endtask

    task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); cmd = c; addr = a; data = d; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        model(c, a, d);
    endtask

    task automatic do_clear();
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        for (int i = 0; i < 4; i++) begin m_ca[i] = '0; m_sa[i] = '0; end
        m_flag = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ci[i] = '0; m_ca[i] = '0; m_si[i] = '0; m_sa[i] = '0; m_sl[i] = 1'b0;
        end
        m_flag = 1'b0; m_rb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 R3: address sweep with arithmetic payloads
        for (int a = 0; a < 16; a++) begin
            send(4'b0000, 4'(a), 16'(a * 16'h1357 + 16'h0101));
            send(4'b0001, 4'(a), 16'(a + 3));
            check_all("R2");
            send(4'b0010, 4'(a), 16'h0);
            check_all("R3");
        end
        for (int c = 0; c < 16; c++) begin
            if (c != 0 && c != 1 && c != 2 && c != 10 && c != 14) begin
                send(4'(c), 4'hF, 16'hDEAD);
                check_all("R2 unlisted opcode");
            end
        end

        // R8 R9 R10 R11: every sleep pattern
        for (int m = 0; m < 16; m++) begin
            send(4'b0010, 4'hF, 16'h0);
            for (int i = 0; i < 4; i++) if (m[i]) send(4'b1110, 4'(i), 16'h0);
            check_all("R8 R9");
            for (int i = 0; i < 4; i++) begin
                send(4'b1010, 4'(i), 16'h0);
                check_all("R11");
            end
            send(4'b1010, 4'hF, 16'h0);
            check_all("R11 all-address read ignored");
        end
        send(4'b0000, 4'd2, 16'hBEEF);
        send(4'b0010, 4'd2, 16'h0);
        check_all("R10");

        // R5 R7: clear then restore
        do_clear();
        check_all("R5 clear");
        send(4'b0010, 4'hF, 16'h0);
        check_all("R5 restore");

        // R7: low supply, non-update and invalid update keep flag low
        @(negedge clk); low_supply = 1'b1;
        @(negedge clk); low_supply = 1'b0;
        m_flag = 1'b0;
        check_all("R7 low supply");
        send(4'b0000, 4'd1, 16'h1234);
        send(4'b0010, 4'd7, 16'h0);
        check_all("R7 stays low");
        send(4'b0010, 4'd1, 16'h0);
        check_all("R7 rises");

        // R6: clear inside an open frame aborts it
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1; cmd = 4'b0000; addr = 4'd0; data = 16'hAAAA; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin m_ca[i] = '0; m_sa[i] = '0; end
        m_flag = 1'b0;
        check_all("R6 aborted");
        send(4'b0010, 4'd0, 16'h0);
        check_all("R6 input intact");

        // R12: second strobe in a frame ignored
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); cmd = 4'b0000; addr = 4'd3; data = 16'h5A5A; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk); data = 16'hC3C3; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        model(4'b0000, 4'd3, 16'h5A5A);
        send(4'b0010, 4'd3, 16'h0);
        check_all("R12");

        // R4: load strobe copies and wakes all
        send(4'b1110, 4'hF, 16'h0);
        send(4'b0000, 4'd0, 16'h0F0F);
        send(4'b0001, 4'd2, 16'h0009);
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        for (int i = 0; i < 4; i++) begin m_ca[i] = m_ci[i]; m_sa[i] = m_si[i]; m_sl[i] = 1'b0; end
        check_all("R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule